// File: doc/BRIEF.md
# Shared Memory Port Arbiter with Address Generators

This block lets several processor ports share one single-ported memory of 8192 words of 16 bits (16 KB). The array can do one read or one write per clock. Each port raises a request, and an arbiter grants exactly one requesting port in that cycle. Two orders are available: a fixed order in which port 0 is highest, and a rotating order that prevents starvation. The arbiter works out the grant combinationally, and the granted access goes to the memory in the same cycle.

A port does not supply an address. Each port has its own programmable address generator, with a base, a stride, a wrap limit and a mode. The modes are sequential, strided and circular. A processor can therefore stream a buffer through the memory by raising requests alone. The generator advances only when its port is granted. Read data comes back on the next cycle, with a valid strobe on the port that asked for it and on no other port. A small write-only configuration interface sets the generator fields of any port and the arbitration order.

The memory array sits outside the block. The block drives a synchronous single-port interface: enable, write enable, address and write data, with read data registered by the array.

Top module: `shmem_ctrl`

## Requirements
- R1: After reset, no port is granted, every read-valid strobe is 0, and arbitration is fixed-order. Each generator holds base 0, stride 0, limit 0, sequential mode and pointer 0. The last-granted port resets to the highest port, so port 0 comes first in rotating order.
- R2: In any cycle, at most one port is granted, and only a port whose request is high. If any request is high, one port is granted. In fixed order (arbitration bit 0 = 0), the lowest-numbered requesting port wins.
- R3: With arbitration bit 0 = 1, the search for a winner starts at the port after the last granted one and wraps around. Every grant in either order updates the last granted port.
- R4: In the cycle of a grant, memEn is 1. memWe equals the granted port's write flag, memAddr equals that port's pointer, and memWdata equals that port's write data. With no grant, memEn is 0.
- R5: A granted read raises portRvalid for that port only, one cycle later. portRdata of that port then carries memRdata. Ports whose valid strobe is low show zero data.
- R6: In sequential mode (mode code 0, and also the unused code 3), a granted access moves the pointer up by 1, modulo 8192.
- R7: In strided mode (mode code 1), a granted access adds the stride to the pointer, modulo 8192.
- R8: In circular mode (mode code 2), a granted access computes pointer + stride. If that sum is at or above the limit, the pointer returns to the base; otherwise it takes the sum.
- R9: The pointer of a port that is not granted keeps its value while the port waits.
- R10: A configuration write selects a field by cfgSel: 0 base, 1 stride, 2 limit, 3 mode (data bits 1:0), 4 arbitration order (data bit 0, port ignored). It takes effect from the next cycle. Writing the base or the mode reloads that port's pointer with the base, and this reload wins over an advance in the same cycle.
- R11: Data written by a granted write is stored at that port's pointer. A later read of that address returns the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portReq | input | NUM_PORTS | Access request per port |
| portWe | input | NUM_PORTS | Write flag per port (1 = write, 0 = read) |
| portWdata | input | NUM_PORTS x DATA_W | Write data per port |
| portGnt | output | NUM_PORTS | One-hot grant, same cycle as the request |
| portRvalid | output | NUM_PORTS | Read data valid, one cycle after a read grant |
| portRdata | output | NUM_PORTS x DATA_W | Read data per port, zero when not valid |
| cfgWe | input | 1 | Configuration write strobe |
| cfgPort | input | PIDX_W | Port whose generator is written |
| cfgSel | input | 3 | Field select (0 base, 1 stride, 2 limit, 3 mode, 4 arbitration) |
| cfgWdata | input | ADDR_W | Configuration value |
| memEn | output | 1 | Memory access enable |
| memWe | output | 1 | Memory write enable |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Registered memory read data |

## Verification
Three results have different due times. The grant and the memory enable, write enable, address and write data are due in the same cycle as the request. Read data and its valid strobe are due one cycle after a read grant. A pointer step or configuration change shows up only at the next access of that port. The bench drives every input just after the falling edge and samples 1 ns later, before the rising edge consumes the inputs. At that point it compares the same-cycle outputs against its model. It also compares the read strobe and data against what the model expected from the previous cycle. Only after these comparisons does it advance its model's pointers, memory image and last-granted port to their values after the coming edge.

// File: rtl/shmem_pkg.sv
package shmem_pkg;
  parameter int unsigned SHM_PORTS  = 4;
  parameter int unsigned SHM_DATA_W = 16;
  parameter int unsigned SHM_ADDR_W = 13;
  localparam int unsigned SHM_PIDX_W = (SHM_PORTS > 1) ? $clog2(SHM_PORTS) : 1;

  typedef enum logic [1:0] {
    AGEN_SEQ    = 2'd0,
    AGEN_STRIDE = 2'd1,
    AGEN_CIRC   = 2'd2,
    AGEN_SPARE  = 2'd3
  } agenMode_e;

  typedef enum logic [2:0] {
    CFG_BASE   = 3'd0,
    CFG_STRIDE = 3'd1,
    CFG_LIMIT  = 3'd2,
    CFG_MODE   = 3'd3,
    CFG_ARB    = 3'd4
  } cfgSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                  access;
    logic                  write;
    logic [SHM_PIDX_W-1:0] gntIdx;
    logic                  cfgWr;
    cfgSel_e               cfgSel;
    logic [SHM_PIDX_W-1:0] cfgPort;
  } ctrlStrobe_t;
endpackage

// File: rtl/shmem_agen.sv
module shmem_agen
  import shmem_pkg::*;
#(
  parameter int unsigned ADDR_W = SHM_ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  cfgSel_e           cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              advance,
  output logic [ADDR_W-1:0] ptr
);
  localparam int unsigned SUM_W = ADDR_W + 1;

  logic [ADDR_W-1:0] baseQ, strideQ, limitQ, ptrQ, nextPtr;
  agenMode_e         modeQ;
  logic [SUM_W-1:0]  stepSum;
  logic [ADDR_W-1:0] stepAmt;

  always_comb begin
    stepAmt = (modeQ == AGEN_STRIDE || modeQ == AGEN_CIRC) ? strideQ : ADDR_W'(1);
    stepSum = {1'b0, ptrQ} + {1'b0, stepAmt};
    if (modeQ == AGEN_CIRC && stepSum >= {1'b0, limitQ}) nextPtr = baseQ;
    else                                                  nextPtr = stepSum[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ   <= '0;
      strideQ <= '0;
      limitQ  <= '0;
      modeQ   <= AGEN_SEQ;
      ptrQ    <= '0;
    end else begin
      if (cfgWr && cfgSel == CFG_BASE)   baseQ   <= cfgData;
      if (cfgWr && cfgSel == CFG_STRIDE) strideQ <= cfgData;
      if (cfgWr && cfgSel == CFG_LIMIT)  limitQ  <= cfgData;
      if (cfgWr && cfgSel == CFG_MODE)   modeQ   <= agenMode_e'(cfgData[1:0]);
      if (cfgWr && cfgSel == CFG_BASE)      ptrQ <= cfgData;
      else if (cfgWr && cfgSel == CFG_MODE) ptrQ <= baseQ;
      else if (advance)                     ptrQ <= nextPtr;
    end
  end

  assign ptr = ptrQ;
endmodule

// File: rtl/shmem_ctl.sv
module shmem_ctl
  import shmem_pkg::*;
#(
  parameter int unsigned NUM_PORTS = SHM_PORTS,
  localparam int unsigned PIDX_W   = SHM_PIDX_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] portReq,
  input  logic [NUM_PORTS-1:0] portWe,
  input  logic                 cfgWe,
  input  logic [PIDX_W-1:0]    cfgPort,
  input  logic [2:0]           cfgSel,
  input  logic                 cfgArbBit,
  output logic [NUM_PORTS-1:0] portGnt,
  output ctrlStrobe_t          strobe
);
  logic              rotateQ;
  logic [PIDX_W-1:0] lastIdxQ;
  logic              found;
  logic [PIDX_W-1:0] gntIdx;
  int                cand;

  always_comb begin
    found  = 1'b0;
    gntIdx = '0;
    cand   = 0;
    for (int k = 0; k < int'(NUM_PORTS); k++) begin
      cand = rotateQ ? (int'(lastIdxQ) + 1 + k) % int'(NUM_PORTS) : k;
      if (!found && portReq[PIDX_W'(cand)]) begin
        found  = 1'b1;
        gntIdx = PIDX_W'(cand);
      end
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_gnt
    assign portGnt[p] = found && (gntIdx == PIDX_W'(p));
  end

  always_comb begin
    strobe.access  = found;
    strobe.write   = found && portWe[gntIdx];
    strobe.gntIdx  = gntIdx;
    strobe.cfgWr   = cfgWe;
    strobe.cfgSel  = cfgSel_e'(cfgSel);
    strobe.cfgPort = cfgPort;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rotateQ  <= 1'b0;
      lastIdxQ <= PIDX_W'(NUM_PORTS - 1);
    end else begin
      if (cfgWe && cfgSel_e'(cfgSel) == CFG_ARB) rotateQ <= cfgArbBit;
      if (found) lastIdxQ <= gntIdx;
    end
  end
endmodule

// File: rtl/shmem_dp.sv
module shmem_dp
  import shmem_pkg::*;
#(
  parameter int unsigned NUM_PORTS = SHM_PORTS,
  parameter int unsigned DATA_W    = SHM_DATA_W,
  parameter int unsigned ADDR_W    = SHM_ADDR_W,
  localparam int unsigned PIDX_W   = SHM_PIDX_W
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctrlStrobe_t                       strobe,
  input  logic [ADDR_W-1:0]                 cfgWdata,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  portWdata,
  input  logic [DATA_W-1:0]                 memRdata,
  output logic                              memEn,
  output logic                              memWe,
  output logic [ADDR_W-1:0]                 memAddr,
  output logic [DATA_W-1:0]                 memWdata,
  output logic [NUM_PORTS-1:0]              portRvalid,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]  portRdata
);
  logic [NUM_PORTS-1:0][ADDR_W-1:0] ptrs;
  logic [NUM_PORTS-1:0]             rvalidQ;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    shmem_agen #(.ADDR_W(ADDR_W)) i_agen (
      .clk     (clk),
      .rstN    (rstN),
      .cfgWr   (strobe.cfgWr && strobe.cfgPort == PIDX_W'(p)),
      .cfgSel  (strobe.cfgSel),
      .cfgData (cfgWdata),
      .advance (strobe.access && strobe.gntIdx == PIDX_W'(p)),
      .ptr     (ptrs[p])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rvalidQ[p] <= 1'b0;
      else       rvalidQ[p] <= strobe.access && !strobe.write && strobe.gntIdx == PIDX_W'(p);
    end

    assign portRdata[p] = rvalidQ[p] ? memRdata : '0;
  end

  assign memEn      = strobe.access;
  assign memWe      = strobe.access && strobe.write;
  assign memAddr    = ptrs[strobe.gntIdx];
  assign memWdata   = portWdata[strobe.gntIdx];
  assign portRvalid = rvalidQ;
endmodule

// File: rtl/shmem_ctrl.sv
module shmem_ctrl
  import shmem_pkg::*;
#(
  parameter int unsigned NUM_PORTS = SHM_PORTS,
  parameter int unsigned DATA_W    = SHM_DATA_W,
  parameter int unsigned ADDR_W    = SHM_ADDR_W,
  localparam int unsigned PIDX_W   = SHM_PIDX_W
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_PORTS-1:0]             portReq,
  input  logic [NUM_PORTS-1:0]             portWe,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] portWdata,
  output logic [NUM_PORTS-1:0]             portGnt,
  output logic [NUM_PORTS-1:0]             portRvalid,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] portRdata,
  input  logic                             cfgWe,
  input  logic [PIDX_W-1:0]                cfgPort,
  input  logic [2:0]                       cfgSel,
  input  logic [ADDR_W-1:0]                cfgWdata,
  output logic                             memEn,
  output logic                             memWe,
  output logic [ADDR_W-1:0]                memAddr,
  output logic [DATA_W-1:0]                memWdata,
  input  logic [DATA_W-1:0]                memRdata
);
  ctrlStrobe_t strobe;

  shmem_ctl #(.NUM_PORTS(NUM_PORTS)) i_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .portReq   (portReq),
    .portWe    (portWe),
    .cfgWe     (cfgWe),
    .cfgPort   (cfgPort),
    .cfgSel    (cfgSel),
    .cfgArbBit (cfgWdata[0]),
    .portGnt   (portGnt),
    .strobe    (strobe)
  );

  shmem_dp #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgWdata   (cfgWdata),
    .portWdata  (portWdata),
    .memRdata   (memRdata),
    .memEn      (memEn),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .portRvalid (portRvalid),
    .portRdata  (portRdata)
  );
endmodule

// File: rtl/shmem_ctrl_chk.sv
module shmem_ctrl_chk #(
  parameter int unsigned NUM_PORTS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PORTS-1:0] portReq,
  input logic [NUM_PORTS-1:0] portWe,
  input logic [NUM_PORTS-1:0] portGnt,
  input logic [NUM_PORTS-1:0] portRvalid,
  input logic                 memEn,
  input logic                 memWe
);
  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(portGnt)); // R2
  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rstN) (portGnt & ~portReq) == '0); // R2
  AST_REQ_GETS_GRANT: assert property (@(posedge clk) disable iff (!rstN) (|portReq) |-> (|portGnt)); // R2
  AST_MEM_FOLLOWS_GRANT: assert property (@(posedge clk) disable iff (!rstN) memEn == (|portGnt)); // R4
  AST_WRITE_MATCHES_PORT: assert property (@(posedge clk) disable iff (!rstN) memEn |-> (memWe == (|(portGnt & portWe)))); // R4
  AST_READ_VALID_NEXT: assert property (@(posedge clk) disable iff (!rstN) (|(portGnt & ~portWe)) |=> (portRvalid == $past(portGnt))); // R5
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rstN) !(|(portGnt & ~portWe)) |=> (portRvalid == '0)); // R5
endmodule

bind shmem_ctrl shmem_ctrl_chk #(.NUM_PORTS(NUM_PORTS)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .portReq    (portReq),
  .portWe     (portWe),
  .portGnt    (portGnt),
  .portRvalid (portRvalid),
  .memEn      (memEn),
  .memWe      (memWe)
);

// File: tb/test_shmem_ctrl.sv
module test_shmem_ctrl;
  localparam int NP    = 4;
  localparam int DW    = 16;
  localparam int AW    = 13;
  localparam int DEPTH = 8192;

  logic               clk = 1'b0;
  logic               rstN;
  logic [NP-1:0]      portReq, portWe, portGnt, portRvalid;
  logic [NP-1:0][DW-1:0] portWdata, portRdata;
  logic               cfgWe;
  logic [1:0]         cfgPort;
  logic [2:0]         cfgSel;
  logic [AW-1:0]      cfgWdata;
  logic               memEn, memWe;
  logic [AW-1:0]      memAddr;
  logic [DW-1:0]      memWdata, memRdata;

  always #5 clk = ~clk;

  shmem_ctrl i_shmem_ctrl (
    .clk(clk), .rstN(rstN), .portReq(portReq), .portWe(portWe), .portWdata(portWdata),
    .portGnt(portGnt), .portRvalid(portRvalid), .portRdata(portRdata),
    .cfgWe(cfgWe), .cfgPort(cfgPort), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

  // behavioural single-port array, 8192 x 16, stored sparsely
  logic [DW-1:0] sramMem [int];
  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) sramMem[int'(memAddr)] = memWdata;
      else memRdata <= sramMem.exists(int'(memAddr)) ? sramMem[int'(memAddr)] : '0;
    end
  end

  // reference model state
  int mBase[NP], mStride[NP], mLimit[NP], mMode[NP], mPtr[NP];
  int mRot, mLast;
  int refMem [int];
  logic [NP-1:0] expVld;
  int expData;
  int nTests = 0, nFail = 0;

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string modeTag(input int m);
    if (m == 1) return "R4/R9/R10/R7";
    if (m == 2) return "R4/R9/R10/R8";
    return "R4/R9/R10/R6";
  endfunction

  task automatic modelReset();
    for (int p = 0; p < NP; p++) begin
      mBase[p] = 0; mStride[p] = 0; mLimit[p] = 0; mMode[p] = 0; mPtr[p] = 0;
    end
    mRot = 0; mLast = NP - 1; expVld = '0; expData = 0;
  endtask

  // called 1 ns after the inputs were driven at a falling edge
  task automatic evalCycle();
    int g;
    logic [NP-1:0] expGnt;
    bit reload;
    g = -1;
    for (int k = 0; k < NP; k++) begin
      int c;
      c = mRot ? (mLast + 1 + k) % NP : k;
      if (g < 0 && portReq[c]) g = c;
    end
    expGnt = '0;
    if (g >= 0) expGnt[g] = 1'b1;
    chk(portGnt == expGnt, mRot ? "R3" : "R2", "grant", portGnt, expGnt);
    chk(memEn == (g >= 0), "R4", "memEn", memEn, g >= 0);
    if (g >= 0) begin
      chk(memWe == portWe[g], "R4", "memWe", memWe, portWe[g]);
      chk(int'(memAddr) == mPtr[g], modeTag(mMode[g]), "address", memAddr, mPtr[g]);
      if (portWe[g]) chk(memWdata == portWdata[g], "R4", "memWdata", memWdata, portWdata[g]);
    end
    chk(portRvalid == expVld, "R5", "rvalid", portRvalid, expVld);
    for (int p = 0; p < NP; p++) begin
      int e;
      e = expVld[p] ? expData : 0;
      chk(int'(portRdata[p]) == e, "R5/R11", "rdata", portRdata[p], e);
    end
    // next state of the model
    expVld = '0;
    if (g >= 0) begin
      if (portWe[g]) refMem[mPtr[g]] = int'(portWdata[g]);
      else begin
        expVld[g] = 1'b1;
        expData = refMem.exists(mPtr[g]) ? refMem[mPtr[g]] : 0;
      end
      reload = cfgWe && int'(cfgPort) == g && (cfgSel == 3'd0 || cfgSel == 3'd3);
      if (!reload) begin
        int s;
        if (mMode[g] == 1) mPtr[g] = (mPtr[g] + mStride[g]) % DEPTH;
        else if (mMode[g] == 2) begin
          s = mPtr[g] + mStride[g];
          mPtr[g] = (s >= mLimit[g]) ? mBase[g] : s % DEPTH;
        end else mPtr[g] = (mPtr[g] + 1) % DEPTH;
      end
      mLast = g;
    end
    if (cfgWe) begin
      int cp;
      cp = int'(cfgPort);
      case (cfgSel)
        3'd0: begin mBase[cp] = int'(cfgWdata); mPtr[cp] = int'(cfgWdata); end
        3'd1: mStride[cp] = int'(cfgWdata);
        3'd2: mLimit[cp] = int'(cfgWdata);
        3'd3: begin mMode[cp] = int'(cfgWdata[1:0]); mPtr[cp] = mBase[cp]; end
        3'd4: mRot = int'(cfgWdata[0]);
        default: ;
      endcase
    end
  endtask

  task automatic drive(input logic [NP-1:0] rq, input logic [NP-1:0] wr,
                       input logic cw, input int cp, input int cs, input int cd);
    @(negedge clk);
    portReq = rq; portWe = wr;
    for (int p = 0; p < NP; p++) portWdata[p] = DW'($urandom);
    cfgWe = cw; cfgPort = 2'(cp); cfgSel = 3'(cs); cfgWdata = AW'(cd);
    #1;
    evalCycle();
  endtask

  task automatic cfg(input int cp, input int cs, input int cd);
    drive('0, '0, 1'b1, cp, cs, cd);
  endtask

  task automatic randomRun(input int n, input int wrOdds, input int cfgOdds);
    for (int i = 0; i < n; i++) begin
      logic [NP-1:0] wr;
      for (int p = 0; p < NP; p++) wr[p] = ($urandom % wrOdds) == 0;
      if (cfgOdds > 0 && ($urandom % cfgOdds) == 0)
        drive(NP'($urandom), wr, 1'b1, int'($urandom % NP), int'($urandom % 4), int'($urandom % DEPTH));
      else
        drive(NP'($urandom), wr, 1'b0, 0, 0, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; portReq = '0; portWe = '0; portWdata = '0;
    cfgWe = 1'b0; cfgPort = '0; cfgSel = '0; cfgWdata = '0;
    modelReset();
    repeat (3) @(negedge clk);
    #1;
    // R1: outputs quiet while in reset
    chk(portRvalid == '0, "R1", "rvalid in reset", portRvalid, 0);
    chk(memEn == 1'b0, "R1", "memEn in reset", memEn, 0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(portGnt == '0, "R1", "grant after reset", portGnt, 0);
    // R1: defaults give pointer 0, sequential stepping
    drive(4'b0001, 4'b0000, 1'b0, 0, 0, 0);
    drive(4'b0001, 4'b0000, 1'b0, 0, 0, 0);
    // R10: program each generator
    cfg(0, 0, 100);
    cfg(1, 1, 3);  cfg(1, 3, 1); cfg(1, 0, 200);
    cfg(2, 1, 4);  cfg(2, 2, 62); cfg(2, 0, 50); cfg(2, 3, 2);
    cfg(3, 1, 5);  cfg(3, 3, 1); cfg(3, 0, 8190);
    // R11: all ports write, fixed priority (R2), waiting ports hold (R9)
    for (int i = 0; i < 12; i++) drive(4'b1111, 4'b1111, 1'b0, 0, 0, 0);
    randomRun(150, 1, 0);
    // R10: base rewrite in the same cycle as a grant wins over the step
    drive(4'b0001, 4'b0000, 1'b1, 0, 0, 100);
    drive(4'b0010, 4'b0000, 1'b1, 1, 0, 200);
    cfg(2, 0, 50); cfg(3, 0, 8190);
    // read everything back
    randomRun(150, 100000, 0);
    // R3: rotating order
    cfg(0, 4, 1);
    for (int i = 0; i < 16; i++) drive(4'b1111, 4'b0000, 1'b0, 0, 0, 0);
    randomRun(300, 4, 16);
    // back to fixed order, with reconfiguration traffic
    cfg(0, 4, 0);
    randomRun(300, 3, 12);
    drive('0, '0, 1'b0, 0, 0, 0);
    drive('0, '0, 1'b0, 0, 0, 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule